// File: doc/BRIEF.md
# Extended-range multi-modulus integer divider

This block divides an input clock by a programmable integer ratio between 32 and 504 in steps of 4. It is modelled as synchronous logic that runs on the clock it divides. A fixed divide-by-4 prescaler produces one enable tick per four input clocks. The ticks drive a cascade of divide-by-2/3 cells. In each chain cycle, a cell whose control bit is set swallows one extra input tick. A chain of n active cells therefore divides by 2^n plus the binary weight of the control bits below the top. To reach small moduli, gate logic shortens the active cascade. The cells above the most significant set bit of the modulus are disabled, and the chain output is taken from the highest active cell.

The ratio word is continuous. The block rounds it and clamps it to a legal modulus. The modulus is taken over only at the boundary between output periods, so every period is built from one ratio alone. The output is a one-clock pulse per period. A companion flag marks the pulses at which a different modulus took effect.

Top module: `dmm_divider`

## Requirements
- R1: The effective ratio is 4 times the chain modulus M. Consecutive rising edges of `pulse_o` are exactly 4*M input clocks apart.
- R2: Every ratio request from 32 to 504 that is a multiple of 4 gives exactly that many input clocks between consecutive pulses.
- R3: A request r maps to M = floor((r+2)/4), and M is then clamped to the range 8..126. Requests below 32 act as 32, requests above 504 act as 504, and any other request goes to the nearest multiple of 4, with a tie rounding up.
- R4: `ratio_i` is sampled only at the rising clock edge where `pulse_o` rises. Changes between two such edges have no effect on the period in progress. The next period uses the value present at that boundary edge.
- R5: `pulse_o` is high for exactly one input clock per period.
- R6: While `rst_i` is high, `pulse_o` and `upd_o` stay low. After release, the first pulse rises at the 4*M-th rising edge, where M comes from the ratio held at the last reset cycle.
- R7: `upd_o` is high only together with `pulse_o`. It is high at a boundary exactly when the new modulus differs from the one of the period just ended. The first boundary after reset uses the modulus loaded in reset.
- R8: Moduli whose low chain bits are all zero (8, 16, 32, 64) and moduli whose bits below the top are all ones (15, 31, 63) divide exactly. The active chain length follows the top set bit of M.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_i | input | RATIO_W (9) | Requested division ratio |
| pulse_o | output | 1 | One-clock pulse per output period |
| upd_o | output | 1 | High with the pulse when a changed modulus took effect |

## Verification
Every result appears at the rising edge that ends a period. The output register raises `pulse_o` and `upd_o` at that same edge, 4*M edges after the previous pulse or after reset release. The bench drives inputs and samples on falling edges. It counts falling edges from one observed pulse to the next, so the measured gap must equal 4*M of the modulus latched at the previous boundary. The flag is read in the same sample as the pulse it belongs to. Ratio changes made inside a period are expected to appear only in the gap after the next pulse.

// File: rtl/dmm_pkg.sv
package dmm_pkg;

   // Round a requested ratio to the nearest prescaler multiple and clamp the
   // resulting chain modulus to the legal window.
   function automatic int unsigned ratio_to_mod(int unsigned req,
                                                int unsigned pre,
                                                int unsigned lo,
                                                int unsigned hi);
      int unsigned m;
      m = (req + pre / 2) / pre;
      if (m < lo)      m = lo;
      else if (m > hi) m = hi;
      return m;
   endfunction

endpackage

// File: rtl/dmm_prescale.sv
module dmm_prescale #(
   parameter int DIV = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic tick_o
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

   generate
      if (DIV == 2) begin : g_toggle
         logic ph_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) ph_q <= 1'b0;
            else       ph_q <= ~ph_q;
         end
         assign tick_o = ph_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)                          cnt_q <= '0;
            else if (cnt_q == CW'(DIV - 1))     cnt_q <= '0;
            else                                cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/dmm_cell.sv
module dmm_cell (
   input  logic clk_i,
   input  logic rst_i,
   input  logic reload_i,
   input  logic swl_i,
   input  logic tick_i,
   output logic tick_o
);
   logic tog_q;
   logic swl_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || reload_i) begin
         tog_q <= 1'b0;
         swl_q <= swl_i;
      end else if (tick_i) begin
         if (swl_q) swl_q <= 1'b0;
         else       tog_q <= ~tog_q;
      end
   end

   // Passes every second accepted tick; a pending swallow eats one tick.
   assign tick_o = tick_i & ~swl_q & tog_q;
endmodule

// File: rtl/dmm_extend.sv
module dmm_extend #(
   parameter int CELLS = 6
) (
   input  logic [CELLS:0]   mod_i,
   output logic [CELLS-1:0] en_o,
   output logic [CELLS-1:0] swl_o,
   output logic [CELLS-1:0] top_o
);
   int msb;

   always_comb begin
      msb = 0;
      for (int k = 0; k <= CELLS; k++) begin
         if (mod_i[k]) msb = k;
      end
   end

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_ctl
         assign en_o[i]  = (i < msb);
         assign swl_o[i] = mod_i[i] & (i < msb);
         assign top_o[i] = (msb == i + 1);
      end
   endgenerate
endmodule

// File: rtl/dmm_divider.sv
module dmm_divider
   import dmm_pkg::*;
#(
   parameter int RATIO_W   = 9,
   parameter int PRE_DIV   = 4,
   parameter int CELLS     = 6,
   parameter int MIN_RATIO = 32,
   parameter int MAX_RATIO = 504
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               pulse_o,
   output logic               upd_o
);
   localparam int MOD_W   = CELLS + 1;
   localparam int MIN_MOD = MIN_RATIO / PRE_DIV;
   localparam int MAX_MOD = MAX_RATIO / PRE_DIV;

   generate
      if (PRE_DIV < 2)                    begin : g_bad_pre   $error("prescaler must divide by 2 or more"); end
      if (MIN_RATIO % PRE_DIV != 0)       begin : g_bad_min   $error("minimum ratio must be a prescaler multiple"); end
      if (MIN_MOD < 4)                    begin : g_bad_floor $error("chain modulus floor below 4"); end
      if (MAX_MOD >= (1 << MOD_W))        begin : g_bad_top   $error("chain too short for maximum ratio"); end
      if (MAX_RATIO >= (1 << RATIO_W))    begin : g_bad_word  $error("ratio word too narrow"); end
      if (MAX_RATIO < MIN_RATIO)          begin : g_bad_range $error("empty ratio range"); end
   endgenerate

   logic [MOD_W-1:0] mod_q;
   logic [MOD_W-1:0] mod_nxt;
   logic [CELLS-1:0] en_nxt, swl_nxt, top_nxt;
   logic [CELLS-1:0] en_q, top_q;
   logic [CELLS:0]   tk;
   logic             pre_tick;
   logic             chain_end;

   always_comb begin
      mod_nxt = MOD_W'(ratio_to_mod(32'(ratio_i), PRE_DIV, MIN_MOD, MAX_MOD));
   end

   dmm_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_o (pre_tick)
   );

   dmm_extend #(.CELLS(CELLS)) u_ext (
      .mod_i (mod_nxt),
      .en_o  (en_nxt),
      .swl_o (swl_nxt),
      .top_o (top_nxt)
   );

   assign tk[0] = pre_tick;

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_cell
         dmm_cell u_cell (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .reload_i (chain_end),
            .swl_i    (swl_nxt[i]),
            .tick_i   (tk[i] & en_q[i]),
            .tick_o   (tk[i+1])
         );
      end
   endgenerate

   // Output is taken from the highest active cell; higher cells are bypassed.
   assign chain_end = |(top_q & tk[CELLS:1]);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mod_q   <= mod_nxt;
         en_q    <= en_nxt;
         top_q   <= top_nxt;
         pulse_o <= 1'b0;
         upd_o   <= 1'b0;
      end else begin
         pulse_o <= chain_end;
         upd_o   <= chain_end && (mod_nxt != mod_q);
         if (chain_end) begin
            mod_q <= mod_nxt;
            en_q  <= en_nxt;
            top_q <= top_nxt;
         end
      end
   end
endmodule

// File: rtl/dmm_divider_chk.sv
module dmm_divider_chk #(
   parameter int MOD_W   = 7,
   parameter int PRE_DIV = 4,
   parameter int MIN_MOD = 8,
   parameter int MAX_MOD = 126
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             pulse_o,
   input logic             upd_o,
   input logic             chain_end,
   input logic [MOD_W-1:0] mod_q,
   input logic [MOD_W-1:0] mod_nxt
);
   localparam int GW = MOD_W + $clog2(PRE_DIV) + 2;

   logic [GW-1:0]    gap_q;
   logic [MOD_W-1:0] per_mod_q;
   logic             armed_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gap_q     <= '0;
         per_mod_q <= '0;
         armed_q   <= 1'b0;
      end else begin
         if (pulse_o)           gap_q <= GW'(1);
         else if (~&gap_q)      gap_q <= gap_q + 1'b1;
         if (pulse_o) per_mod_q <= mod_q;
         armed_q <= armed_q | pulse_o;
      end
   end

   p_gap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (pulse_o && armed_q) |-> (gap_q == GW'(PRE_DIV) * GW'(per_mod_q)));

   p_mod_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (mod_q >= MOD_W'(MIN_MOD)) && (mod_q <= MOD_W'(MAX_MOD)));

   p_mod_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      !chain_end |=> $stable(mod_q));

   p_mod_load_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      chain_end |=> (mod_q == $past(mod_nxt)));

   p_pulse_narrow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |=> !pulse_o);

   p_quiet_reset_r6: assert property (@(posedge clk_i)
      rst_i |=> (!pulse_o && !upd_o));

   p_upd_with_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      upd_o |-> pulse_o);
endmodule

bind dmm_divider dmm_divider_chk #(
   .MOD_W   (MOD_W),
   .PRE_DIV (PRE_DIV),
   .MIN_MOD (MIN_MOD),
   .MAX_MOD (MAX_MOD)
) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .pulse_o   (pulse_o),
   .upd_o     (upd_o),
   .chain_end (chain_end),
   .mod_q     (mod_q),
   .mod_nxt   (mod_nxt)
);

// File: tb/dmm_divider_tb.sv
module dmm_divider_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [8:0] ratio = 9'd40;
   logic       pulse;
   logic       upd;

   int tests = 0;
   int errs  = 0;
   int cur_m;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dmm_divider dut_i (
      .clk_i   (clk),
      .rst_i   (rst),
      .ratio_i (ratio),
      .pulse_o (pulse),
      .upd_o   (upd)
   );

   function automatic int exp_mod(int r);
      int m;
      m = (r + 2) / 4;
      if (m < 8)   m = 8;
      if (m > 126) m = 126;
      return m;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Counts falling edges from one seen pulse to the next; optionally
   // changes the ratio at given offsets inside the period.
   task automatic measure(output int gap, output bit u,
                          input int at_a, input int val_a,
                          input int at_b, input int val_b);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
         if (gap == 1) check(pulse == 1'b0, "R5 pulse width", int'(pulse), 0);
         if (gap == at_a) ratio = 9'(val_a);
         if (gap == at_b) ratio = 9'(val_b);
      end while (!pulse);
      u = upd;
   endtask

   task automatic step(int r, string req);
      int g; bit u; int nm;
      ratio = 9'(r);
      nm = exp_mod(r);
      measure(g, u, -1, 0, -1, 0);
      check(g == 4 * cur_m, req, g, 4 * cur_m);
      check(u == (nm != cur_m), "R7 update flag", int'(u), int'(nm != cur_m));
      cur_m = nm;
   endtask

   initial begin
      int g; bit u; int seed; int r;
      seed = int'($urandom(32'd20240601));
      // Reset state
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(pulse == 1'b0 && upd == 1'b0, "R6 quiet in reset", int'(pulse) + int'(upd), 0);
      end
      rst = 1'b0;
      cur_m = exp_mod(40);
      measure(g, u, -1, 0, -1, 0);
      check(g == 4 * cur_m, "R6 first period", g, 4 * cur_m);
      check(u == 1'b0, "R7 no flag on first boundary", int'(u), 0);

      // Sweep every legal ratio (R2); each gap checks the previous ratio
      for (int rr = 32; rr <= 504; rr += 4) step(rr, "R2 legal ratio");
      step(40, "R2 legal ratio 504");

      // Chain length extremes (R8)
      step(32,  "R8 ratio");  step(64,  "R8 ratio 32");
      step(128, "R8 ratio 64"); step(256, "R8 ratio 128");
      step(60,  "R8 ratio 256"); step(124, "R8 ratio 60");
      step(252, "R8 ratio 124"); step(32, "R8 ratio 252");

      // Rounding and clamping (R3)
      step(0,   "R3 request"); step(5,   "R3 request 0");
      step(31,  "R3 request 5"); step(33,  "R3 request 31");
      step(34,  "R3 request 33"); step(35,  "R3 request 34");
      step(502, "R3 request 35"); step(503, "R3 request 502");
      step(505, "R3 request 503"); step(511, "R3 request 505");
      step(131, "R3 request 511"); step(250, "R3 request 131");
      step(48,  "R3 request 250");

      // Mid-period changes (R4): only the value at the boundary counts
      measure(g, u, 3, 300, 9, 100);
      check(g == 4 * cur_m, "R4 current period kept", g, 4 * cur_m);
      check(u == (exp_mod(100) != cur_m), "R7 flag after change", int'(u), int'(exp_mod(100) != cur_m));
      cur_m = exp_mod(100);
      measure(g, u, 2, 480, 7, 36);
      check(g == 4 * cur_m, "R4 boundary value used", g, 4 * cur_m);
      cur_m = exp_mod(36);
      measure(g, u, -1, 0, -1, 0);
      check(g == 4 * cur_m, "R4 last value wins", g, 4 * cur_m);
      check(u == 1'b0, "R7 unchanged modulus", int'(u), 0);

      // Constrained random requests (R1)
      for (int k = 0; k < 30; k++) begin
         r = int'($urandom_range(0, 511));
         step(r, "R1 random ratio");
      end

      // Reset in mid period (R6)
      repeat (20) @(negedge clk);
      rst = 1'b1;
      ratio = 9'd200;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(pulse == 1'b0 && upd == 1'b0, "R6 quiet in reset", int'(pulse) + int'(upd), 0);
      end
      rst = 1'b0;
      cur_m = exp_mod(200);
      measure(g, u, -1, 0, -1, 0);
      check(g == 4 * cur_m, "R6 first period after reset", g, 4 * cur_m);
      check(u == 1'b0, "R7 no flag after reset", int'(u), 0);
      measure(g, u, -1, 0, -1, 0);
      check(g == 4 * cur_m, "R1 steady period", g, 4 * cur_m);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, errs);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         errs++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, errs);
         $finish;
      end
   end
endmodule